// File: doc/BRIEF.md
# Multi-Slot Conversion Sequencer

This block orders the conversions of an analog converter core across sixteen slots. Each slot has an 8-bit control byte that sets the input channel, the reference choice and an end-of-run marker. A hidden slot pointer chooses the slot that the converter core uses next. The block requests each conversion with a one-cycle start pulse. It stores each 12-bit result in the matching entry of a sixteen-entry result memory, and for every store it pulses that slot's flag line.

Four run modes are available: one conversion, one pass over a run of slots, endless conversion of one slot, and endless passes over a run. An automatic-chaining option starts each conversion as soon as the previous one ends, so that only the first trigger is needed. Configuration is accepted only while the enable input is low. What happens when enable falls depends on the mode: the block can abort at once, finish the current conversion, or finish the current run. A run that has no end marker does not stop when enable falls. It can be stopped at once by switching to one-conversion mode while enable is low.

Top module: `slot_sequencer`

## Requirements
- R1: After reset, busy, conv_start, res_we and flag_set are all 0.
- R2: A control byte holds the end-of-run marker in bit 7, the reference select in bits 6:4 and the channel in bits 3:0. While idle, the pointer rests on the configured first slot, and chan_sel/ref_sel show that slot's fields two cycles after a configuration write.
- R3: A control-byte write or a configuration write made while enable is 1 is ignored.
- R4: In mode 00 (one conversion), one accepted trigger gives one conversion into the first slot, and busy falls when that result is stored.
- R5: A result is stored right-justified with the upper 4 of 16 bits zero. In the cycle after conv_done, res_we is 1, res_addr is the slot, res_data is the result, and flag_set has only that slot's bit set. The result can then be read back at rd_addr.
- R6: In mode 01 (one pass), slots are converted from the first slot upward, wrapping from 15 to 0. The pass ends after a slot whose marker is set. Without chaining, each slot needs its own trigger.
- R7: In mode 10 (repeat one slot), every trigger converts the same slot. Clearing enable stops the block after the current conversion, or at once if it is waiting for a trigger.
- R8: In mode 11 (repeat pass), after the marked slot the pointer returns to the first slot and the block waits for a trigger while staying busy.
- R9: With chaining on, timed sampling on and a mode other than 00, the next conv_start is issued in the same cycle as the previous result store. Triggers are ignored while the block runs.
- R10: In mode 00, clearing enable during a conversion aborts it at once: busy falls on the next cycle and a later conv_done stores nothing.
- R11: In modes 01 and 11, clearing enable lets the current pass finish. If no slot is marked, the block keeps running until the mode is set to 00 with enable low, which stops it at once.
- R12: With the software trigger source, the trigger can restart the block freely. With the external source, enable must go low and high again between runs.
- R13: conv_start pulses in the cycle after an accepted trigger. The block never issues conv_start from idle while enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; configuration is locked while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Run mode: 00 one conversion, 01 one pass, 10 repeat one slot, 11 repeat pass |
| cfg_start | input | 4 | First slot |
| cfg_auto | input | 1 | Automatic chaining |
| cfg_timed | input | 1 | Sampling is timed by the sample timer |
| cfg_swsrc | input | 1 | 1 selects the software trigger source |
| ctl_we | input | 1 | Control-byte write strobe |
| ctl_addr | input | 4 | Control-byte slot |
| ctl_data | input | 8 | Control byte {marker, ref[2:0], chan[3:0]} |
| trig | input | 1 | Trigger pulse |
| conv_done | input | 1 | Converter core finished |
| conv_result | input | 12 | Converter core result |
| rd_addr | input | 4 | Result memory read slot |
| conv_start | output | 1 | Start-conversion request pulse |
| chan_sel | output | 4 | Channel of the current slot |
| ref_sel | output | 3 | Reference select of the current slot |
| busy | output | 1 | A run is active |
| res_we | output | 1 | Result store pulse |
| res_addr | output | 4 | Slot being stored |
| res_data | output | 16 | Stored word |
| flag_set | output | 16 | Per-slot store flag pulses |
| rd_data | output | 16 | Result memory read data |

## Verification
The bench drives every input at a falling edge. It reads each output at the falling edge that follows the rising edge expected to produce it. conv_start is expected one cycle after the trigger. res_we, res_addr, res_data and flag_set are expected one cycle after conv_done, with rd_data valid at once after that store. chan_sel and ref_sel are expected two cycles after a configuration write, and busy falls one cycle after an abort or stop condition. For every result the bench computes the slot order and wrap point, the field values and the result words from the slot number, and it checks the exact cycle of each pulse. A pulse that arrives one cycle early or late therefore shows up as a mismatch.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE = 2'b00,
    MODE_SEQ  = 2'b01,
    MODE_RPT  = 2'b10,
    MODE_RSEQ = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_WAIT = 2'b10
  } seq_state_e;

  // control byte layout is fixed: marker, reference, channel
  typedef struct packed {
    logic       last;
    logic [2:0] refsel;
    logic [3:0] chan;
  } slot_ctl_t;
endpackage

// File: rtl/slotseq_table.sv
module slotseq_table
  import slotseq_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  slot_ctl_t     wr_data,
  input  logic [PW-1:0] rd_addr,
  output slot_ctl_t     rd_ctl
);
  slot_ctl_t ent_w [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_ent
    slot_ctl_t q;
    logic      hit;
    assign hit = wr_en && !lock && (wr_addr == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign ent_w[g] = q;
  end

  assign rd_ctl = ent_w[rd_addr];

  assert_ctl_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> ent_w[$past(wr_addr)] == $past(ent_w[wr_addr]));
endmodule

// File: rtl/slotseq_results.sv
module slotseq_results #(
  parameter int SLOTS  = 16,
  parameter int RES_W  = 12,
  parameter int WORD_W = 16,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store,
  input  logic [PW-1:0]     store_addr,
  input  logic [RES_W-1:0]  store_val,
  input  logic [PW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              res_we,
  output logic [PW-1:0]     res_addr,
  output logic [WORD_W-1:0] res_data,
  output logic [SLOTS-1:0]  flag_set
);
  logic [RES_W-1:0] mem_w [SLOTS];
  logic             we_q;
  logic [PW-1:0]    addr_q;
  logic [RES_W-1:0] val_q;
  logic [SLOTS-1:0] flag_q, flag_d;

  for (genvar g = 0; g < SLOTS; g++) begin : g_mem
    logic [RES_W-1:0] q;
    always_ff @(posedge clk) begin
      if (store && (store_addr == PW'(g))) q <= store_val;
    end
    assign mem_w[g] = q;
  end

  always_comb begin
    flag_d = '0;
    if (store) flag_d[store_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      val_q  <= '0;
      flag_q <= '0;
    end else begin
      we_q   <= store;
      flag_q <= flag_d;
      if (store) begin
        addr_q <= store_addr;
        val_q  <= store_val;
      end
    end
  end

  assign res_we   = we_q;
  assign res_addr = addr_q;
  assign res_data = WORD_W'(val_q);
  assign flag_set = flag_q;
  assign rd_data  = WORD_W'(mem_w[rd_addr]);

  assert_flag_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (res_we && $countones(flag_set) == 1 && flag_set[res_addr]));
  assert_flag_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !store |=> (flag_set == '0 && !res_we));
endmodule

// File: rtl/slotseq_ctrl.sv
module slotseq_ctrl
  import slotseq_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [PW-1:0] cfg_start,
  input  logic          cfg_auto,
  input  logic          cfg_timed,
  input  logic          cfg_swsrc,
  input  logic          trig,
  input  logic          conv_done,
  input  logic          slot_last,
  output logic [PW-1:0] ptr,
  output logic          conv_start,
  output logic          busy,
  output logic          store
);
  seq_state_e    state_q, state_d;
  seq_mode_e     mode_q;
  logic [PW-1:0] start_q, ptr_q, ptr_d;
  logic          auto_q, timed_q, swsrc_q;
  logic          armed_q, armed_d, head_q, head_d, go_q, go_d;
  logic          fast, stop_now, finish, adv;

  always_comb begin
    fast     = auto_q && timed_q && (mode_q != MODE_ONCE);
    stop_now = (state_q != ST_IDLE) && (mode_q == MODE_ONCE) && !enable;
    store    = (state_q == ST_CONV) && conv_done && !stop_now;
    state_d  = state_q;
    ptr_d    = ptr_q;
    head_d   = head_q;
    go_d     = 1'b0;
    finish   = 1'b0;
    adv      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        ptr_d  = start_q;
        head_d = 1'b0;
        if (enable && armed_q && trig) begin
          state_d = ST_CONV;
          go_d    = 1'b1;
        end
      end
      ST_CONV: begin
        if (store) begin
          case (mode_q)
            MODE_ONCE: finish = 1'b1;
            MODE_SEQ: begin
              if (slot_last) finish = 1'b1;
              else begin
                ptr_d = ptr_q + 1'b1;
                adv   = 1'b1;
              end
            end
            MODE_RPT: begin
              if (!enable) finish = 1'b1;
              else         adv    = 1'b1;
            end
            default: begin
              if (slot_last) begin
                ptr_d  = start_q;
                head_d = 1'b1;
                if (!enable) finish = 1'b1;
                else         adv    = 1'b1;
              end else begin
                ptr_d  = ptr_q + 1'b1;
                head_d = 1'b0;
                adv    = 1'b1;
              end
            end
          endcase
        end
      end
      ST_WAIT: begin
        if (!enable && ((mode_q == MODE_RPT) || head_q)) finish = 1'b1;
        else if (trig) begin
          state_d = ST_CONV;
          go_d    = 1'b1;
          head_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (adv) begin
      if (fast) begin
        go_d   = 1'b1;
        head_d = 1'b0;
      end else begin
        state_d = ST_WAIT;
      end
    end
    if (finish || stop_now) begin
      state_d = ST_IDLE;
      ptr_d   = start_q;
      head_d  = 1'b0;
    end
    if (stop_now) go_d = 1'b0;
    armed_d = armed_q;
    if (!enable)                  armed_d = 1'b1;
    else if (finish && !swsrc_q) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      mode_q  <= MODE_ONCE;
      start_q <= '0;
      auto_q  <= 1'b0;
      timed_q <= 1'b0;
      swsrc_q <= 1'b0;
      armed_q <= 1'b1;
      head_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      armed_q <= armed_d;
      head_q  <= head_d;
      go_q    <= go_d;
      if (cfg_we && !enable) begin
        mode_q  <= seq_mode_e'(cfg_mode);
        start_q <= cfg_start;
        auto_q  <= cfg_auto;
        timed_q <= cfg_timed;
        swsrc_q <= cfg_swsrc;
      end
    end
  end

  assign ptr        = ptr_q;
  assign conv_start = go_q;
  assign busy       = (state_q != ST_IDLE);

  assert_abort_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == MODE_ONCE && !enable) |=> (!busy && !conv_start));
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (store && mode_q == MODE_SEQ && !slot_last) |=> ptr_q == PW'($past(ptr_q) + 1'b1));
  assert_rpt_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store && mode_q == MODE_RPT && !enable) |=> !busy);
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !conv_start);
  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && enable) |=> ($stable(mode_q) && $stable(start_q)));
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slotseq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int RES_W  = 12,
  parameter int WORD_W = 16,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [PW-1:0]     cfg_start,
  input  logic              cfg_auto,
  input  logic              cfg_timed,
  input  logic              cfg_swsrc,
  input  logic              ctl_we,
  input  logic [PW-1:0]     ctl_addr,
  input  logic [7:0]        ctl_data,
  input  logic              trig,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [PW-1:0]     rd_addr,
  output logic              conv_start,
  output logic [3:0]        chan_sel,
  output logic [2:0]        ref_sel,
  output logic              busy,
  output logic              res_we,
  output logic [PW-1:0]     res_addr,
  output logic [WORD_W-1:0] res_data,
  output logic [SLOTS-1:0]  flag_set,
  output logic [WORD_W-1:0] rd_data
);
  logic [PW-1:0] ptr;
  logic          store;
  slot_ctl_t     cur_ctl;

  slotseq_table #(.SLOTS(SLOTS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (enable),
    .wr_en   (ctl_we),
    .wr_addr (ctl_addr),
    .wr_data (slot_ctl_t'(ctl_data)),
    .rd_addr (ptr),
    .rd_ctl  (cur_ctl)
  );

  slotseq_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_we     (cfg_we),
    .cfg_mode   (cfg_mode),
    .cfg_start  (cfg_start),
    .cfg_auto   (cfg_auto),
    .cfg_timed  (cfg_timed),
    .cfg_swsrc  (cfg_swsrc),
    .trig       (trig),
    .conv_done  (conv_done),
    .slot_last  (cur_ctl.last),
    .ptr        (ptr),
    .conv_start (conv_start),
    .busy       (busy),
    .store      (store)
  );

  slotseq_results #(.SLOTS(SLOTS), .RES_W(RES_W), .WORD_W(WORD_W)) u_results (
    .clk        (clk),
    .rst_n      (rst_n),
    .store      (store),
    .store_addr (ptr),
    .store_val  (conv_result),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .res_we     (res_we),
    .res_addr   (res_addr),
    .res_data   (res_data),
    .flag_set   (flag_set)
  );

  assign chan_sel = cur_ctl.chan;
  assign ref_sel  = cur_ctl.refsel;
endmodule

// File: tb/slot_sequencer_tb.sv
`timescale 1ns/1ps
module slot_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n, enable, cfg_we, cfg_auto, cfg_timed, cfg_swsrc;
  logic [1:0]  cfg_mode;
  logic [3:0]  cfg_start, ctl_addr, rd_addr;
  logic        ctl_we, trig, conv_done;
  logic [7:0]  ctl_data;
  logic [11:0] conv_result;
  logic        conv_start, busy, res_we;
  logic [3:0]  chan_sel, res_addr;
  logic [2:0]  ref_sel;
  logic [15:0] res_data, flag_set, rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_ctl [16];

  always #2.5 clk = ~clk;

  slot_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_start(cfg_start), .cfg_auto(cfg_auto), .cfg_timed(cfg_timed), .cfg_swsrc(cfg_swsrc),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_data(ctl_data), .trig(trig),
    .conv_done(conv_done), .conv_result(conv_result), .rd_addr(rd_addr),
    .conv_start(conv_start), .chan_sel(chan_sel), .ref_sel(ref_sel), .busy(busy),
    .res_we(res_we), .res_addr(res_addr), .res_data(res_data), .flag_set(flag_set),
    .rd_data(rd_data)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [7:0] mk(input int i, input logic last);
    return {last, 3'(i * 3), 4'(i * 5 + 1)};
  endfunction

  task automatic wctl(input int a, input logic [7:0] d);
    ctl_addr = 4'(a); ctl_data = d; ctl_we = 1'b1;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic load_table(input logic markers);
    for (int i = 0; i < 16; i++) begin
      exp_ctl[i] = mk(i, markers && (i == 5 || i == 1));
      wctl(i, exp_ctl[i]);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input int s, input logic a, input logic t, input logic sw);
    cfg_mode = m; cfg_start = 4'(s); cfg_auto = a; cfg_timed = t; cfg_swsrc = sw;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
    tick();
  endtask

  task automatic go(input string tag, input logic exp);
    trig = 1'b1;
    tick();
    trig = 1'b0;
    chk({tag, " conv_start after trigger"}, conv_start, exp);
  endtask

  task automatic done(input string tag, input int a, input logic [11:0] v);
    chk({tag, " chan_sel"}, chan_sel, exp_ctl[a][3:0]);
    chk({tag, " ref_sel"}, ref_sel, exp_ctl[a][6:4]);
    conv_done = 1'b1; conv_result = v;
    tick();
    conv_done = 1'b0;
    chk({tag, " res_we"}, res_we, 1);
    chk({tag, " res_addr"}, res_addr, a);
    chk({tag, " res_data"}, res_data, {4'h0, v});
    chk({tag, " flag_set"}, flag_set, 32'(1) << a);
    rd_addr = 4'(a);
    #1;
    chk({tag, " rd_data"}, rd_data, {4'h0, v});
  endtask

  function automatic logic [11:0] val(input int a, input int k);
    return 12'(a * 257 + k * 13 + 12'h800);
  endfunction

  initial begin
    #100us;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 0; cfg_we = 0; cfg_mode = 0; cfg_start = 0; cfg_auto = 0;
    cfg_timed = 0; cfg_swsrc = 0; ctl_we = 0; ctl_addr = 0; ctl_data = 0; trig = 0;
    conv_done = 0; conv_result = 0; rd_addr = 0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 res_we", res_we, 0);
    chk("R1 flag_set", flag_set, 0);

    // R2 exhaustive field sweep over every first slot
    load_table(1'b1);
    for (int s = 0; s < 16; s++) begin
      cfg(2'b00, s, 0, 0, 1);
      chk("R2 chan_sel sweep", chan_sel, exp_ctl[s][3:0]);
      chk("R2 ref_sel sweep", ref_sel, exp_ctl[s][6:4]);
    end

    // R3 writes locked while enabled
    cfg(2'b00, 3, 0, 0, 1);
    enable = 1'b1;
    wctl(3, 8'h7E);
    cfg(2'b01, 9, 0, 0, 1);
    chk("R3 ctl write ignored chan", chan_sel, exp_ctl[3][3:0]);
    chk("R3 ctl write ignored ref", ref_sel, exp_ctl[3][6:4]);

    // R4 / R5 / R13 one conversion, software source (mode must still be 00)
    go("R13 R4", 1);
    chk("R4 busy during conversion", busy, 1);
    tick();
    chk("R13 single pulse", conv_start, 0);
    done("R4 R5", 3, val(3, 0));
    chk("R4 busy after store", busy, 0);
    // R12 software source restarts freely
    go("R12 sw restart", 1);
    done("R12 sw restart", 3, val(3, 1));

    // R12 external source needs enable toggle
    enable = 1'b0;
    cfg(2'b00, 7, 0, 0, 0);
    enable = 1'b1; tick();
    go("R12 hw first", 1);
    done("R12 hw first", 7, val(7, 2));
    go("R12 hw re-trigger ignored", 0);
    chk("R12 hw idle", busy, 0);
    enable = 1'b0; tick(); enable = 1'b1; tick();
    go("R12 hw after toggle", 1);
    done("R12 hw after toggle", 7, val(7, 3));
    enable = 1'b0;
    tick();
    chk("R13 no start when disabled", conv_start, 0);
    go("R13 disabled trigger", 0);

    // R6 one pass with manual triggers, then wrap 14..1
    cfg(2'b01, 3, 0, 0, 1);
    enable = 1'b1; tick();
    for (int a = 3; a <= 5; a++) begin
      go("R6 pass", 1);
      done("R6 pass", a, val(a, 4));
      chk("R6 no self start", conv_start, 0);
      chk("R6 busy", busy, a != 5);
    end
    enable = 1'b0;
    cfg(2'b01, 14, 0, 0, 1);
    enable = 1'b1; tick();
    for (int k = 0; k < 4; k++) begin
      go("R6 wrap", 1);
      done("R6 wrap", (14 + k) % 16, val((14 + k) % 16, 5));
    end
    chk("R6 wrap ends at marker", busy, 0);

    // R8 repeat pass returns to first slot and waits
    enable = 1'b0;
    cfg(2'b11, 3, 0, 0, 1);
    enable = 1'b1; tick();
    for (int a = 3; a <= 5; a++) begin
      go("R8 pass", 1);
      done("R8 pass", a, val(a, 6));
    end
    chk("R8 still busy", busy, 1);
    chk("R8 pointer back", chan_sel, exp_ctl[3][3:0]);
    go("R8 next pass", 1);
    done("R8 next pass", 3, val(3, 7));
    // R11 enable cleared mid pass: pass completes
    enable = 1'b0;
    tick();
    chk("R11 continues after enable clear", busy, 1);
    go("R11 mid pass", 1);
    done("R11 mid pass", 4, val(4, 8));
    go("R11 last slot", 1);
    done("R11 last slot", 5, val(5, 8));
    chk("R11 stopped at pass end", busy, 0);

    // R7 repeat one slot
    cfg(2'b10, 4, 0, 0, 1);
    enable = 1'b1; tick();
    for (int k = 0; k < 3; k++) begin
      go("R7 repeat", 1);
      done("R7 repeat", 4, val(4, 9 + k));
      chk("R7 busy between", busy, 1);
    end
    enable = 1'b0;
    tick();
    chk("R7 stop while waiting", busy, 0);
    enable = 1'b1; tick();
    go("R7 again", 1);
    enable = 1'b0;
    done("R7 finish current", 4, val(4, 12));
    chk("R7 stopped after current", busy, 0);

    // R9 chained conversions
    cfg(2'b01, 3, 1, 1, 1);
    enable = 1'b1; tick();
    go("R9 first", 1);
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R9 trigger ignored", conv_start, 0);
    done("R9 chain", 3, val(3, 13));
    chk("R9 chained start", conv_start, 1);
    done("R9 chain", 4, val(4, 13));
    chk("R9 chained start", conv_start, 1);
    done("R9 chain", 5, val(5, 13));
    chk("R9 no start after marker", conv_start, 0);
    chk("R9 idle after pass", busy, 0);
    enable = 1'b0;
    cfg(2'b11, 3, 1, 1, 1);
    enable = 1'b1; tick();
    go("R9 repeat pass", 1);
    for (int a = 3; a <= 5; a++) done("R9 repeat pass", a, val(a, 14));
    chk("R9 restart after marker", conv_start, 1);
    enable = 1'b0;
    for (int a = 3; a <= 5; a++) done("R11 chained pass end", a, val(a, 15));
    chk("R11 chained stop", busy, 0);
    cfg(2'b01, 3, 1, 0, 1);
    enable = 1'b1; tick();
    go("R9 untimed", 1);
    done("R9 untimed", 3, val(3, 16));
    chk("R9 untimed needs trigger", conv_start, 0);
    go("R9 untimed", 1);
    done("R9 untimed", 4, val(4, 16));
    go("R9 untimed", 1);
    done("R9 untimed", 5, val(5, 16));

    // R10 abort in one-conversion mode
    enable = 1'b0;
    cfg(2'b00, 2, 0, 0, 1);
    enable = 1'b1; tick();
    go("R10", 1);
    enable = 1'b0;
    tick();
    chk("R10 busy drops at once", busy, 0);
    conv_done = 1'b1; conv_result = 12'hFFF;
    tick();
    conv_done = 1'b0;
    chk("R10 no store", res_we, 0);
    chk("R10 no flag", flag_set, 0);

    // R11 no marker: enable clear does not stop; mode 00 stops
    load_table(1'b0);
    cfg(2'b11, 0, 0, 0, 1);
    enable = 1'b1; tick();
    go("R11 nomark", 1);
    done("R11 nomark", 0, val(0, 17));
    enable = 1'b0;
    go("R11 nomark keeps going", 1);
    done("R11 nomark", 1, val(1, 17));
    tick();
    chk("R11 nomark still busy", busy, 1);
    cfg(2'b00, 0, 0, 0, 1);
    chk("R11 mode 00 stops", busy, 0);
    go("R11 stays stopped", 0);

    summary();
    $finish;
  end
endmodule